// File: doc/BRIEF.md
# Transmit Output Port Formatter

This block takes per-chain I/Q sample words from the summation stage and places them on four 18-bit transmit output ports. A two-bit format code picks one of three mappings. In real mode each chain puts its I word on its own port. In interleaved-complex mode each port carries its chain's I word and then its Q word on the next slot, and a flag marks the I word. In split-complex mode chain 0 drives I and Q on ports 0 and 1, and chain 1 drives I and Q on ports 2 and 3. In split mode the ports update once every two slots.

A rate control sets the slot cadence. With half rate off, every clock is a slot. With half rate on, every second clock is a slot. The output words, flag, strobe and per-port drive enables are all registered and change only on slot edges. Each port has an enable and a high-impedance request. A disabled port outputs zeros. If the port is also asked to float, its drive enable drops so that the pad logic outside the block can tri-state it. The format code is sampled only when a new sample is accepted, so a complex pair is never split across two formats.

Top module: `tx_out_formatter`

## Requirements
- R1: While reset is high, and on the first cycle after it is released, all port words, the I flag, the strobe and the drive enables are zero.
- R2: With half_rate low, every clock edge is a slot. With half_rate high, slots fall on alternate edges, and the first slot is the second edge after half_rate is first sampled high while the internal toggle is clear. No output changes on an edge that is not a slot.
- R3: A sample boundary is a slot at which no complex pair is in progress. When in_valid is high at a boundary and fmt_sel is 0 (real) or 3 (treated as real), port p takes I of chain p. The Q inputs have no effect on the ports, and tx_iflag is 0.
- R4: For fmt_sel 1 (interleaved), port p takes I of chain p at the accepting slot and tx_iflag is 1. At the next slot port p takes the Q captured with that sample and tx_iflag is 0. tx_iflag is 0 after any slot that does not emit an I word.
- R5: For fmt_sel 2 (split), ports 0, 1, 2 and 3 take I0, Q0, I1 and Q1 at the accepting slot. The next slot accepts no sample, leaves the ports unchanged and gives no strobe.
- R6: fmt_sel is sampled only at an accepting boundary. A change in the middle of a pair does not alter how the pair completes.
- R7: When in_valid is low at a boundary, the ports hold their words and tx_stb stays low.
- R8: At each slot, a port whose port_en bit is 0 is loaded with zero in place of its formatted word.
- R9: At each slot, tx_drive is loaded with port_en OR NOT port_hiz.
- R10: tx_stb is high for exactly the cycle after each slot edge that loads new words: an accepted sample, or the Q half of an interleaved pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_rate | input | 1 | 1: a slot on every second clock |
| fmt_sel | input | 2 | 0 real, 1 interleaved, 2 split, 3 real |
| in_valid | input | 1 | A sample is offered on in_i/in_q |
| in_i | input | 72 | I words of chains 0..3, chain p at bits p*18 |
| in_q | input | 72 | Q words of chains 0..3, chain p at bits p*18 |
| port_en | input | 4 | Per-port enable |
| port_hiz | input | 4 | Per-port float request, effective when the port is disabled |
| tx_data | output | 72 | Port words, port p at bits p*18 |
| tx_drive | output | 4 | Per-port drive enable for the pad logic |
| tx_iflag | output | 1 | High while the ports carry interleaved I words |
| tx_stb | output | 1 | Output qualifier: new words were loaded |

## Verification
A bench model steps once per clock and is compared on every cycle with random words, random valid gaps and random format codes, including code 3, at both rates. Directed cases cover several specific situations. One changes the format in the middle of a pair, which shows whether the code is held until the pair ends. One feeds different Q words in real mode, which shows whether Q leaks onto the ports. One is the idle slot after a split load, which separates a true half-rate update from an early reload. Mixed enable and float masks show whether zero forcing and drive enables act on each port on its own.

// File: rtl/tof_pkg.sv
package tof_pkg;
  typedef enum logic [1:0] {
    FMT_REAL  = 2'b00,
    FMT_ILV   = 2'b01,
    FMT_SPLIT = 2'b10
  } fmt_e;

  function automatic fmt_e fmt_decode(input logic [1:0] code);
    case (code)
      2'b01:   return FMT_ILV;
      2'b10:   return FMT_SPLIT;
      default: return FMT_REAL;
    endcase
  endfunction
endpackage

// File: rtl/tof_rate_gen.sv
module tof_rate_gen (
  input  logic clk,
  input  logic rst,
  input  logic half_rate,
  output logic slot
);
  logic tick_q;

  always_ff @(posedge clk) begin
    if (rst) tick_q <= 1'b0;
    else     tick_q <= half_rate ? ~tick_q : 1'b0;
  end

  assign slot = ~half_rate | tick_q;
endmodule

// File: rtl/tof_seq.sv
module tof_seq
  import tof_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       slot,
  input  logic       in_valid,
  input  logic [1:0] fmt_sel,
  output logic       start,
  output logic       cont,
  output fmt_e       mode_now
);
  fmt_e mode_act;
  logic pair_q;

  assign start    = slot & ~pair_q & in_valid;
  assign cont     = slot & pair_q & (mode_act == FMT_ILV);
  assign mode_now = start ? fmt_decode(fmt_sel) : mode_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_act <= FMT_REAL;
      pair_q   <= 1'b0;
    end else if (start) begin
      mode_act <= fmt_decode(fmt_sel);
      pair_q   <= (fmt_decode(fmt_sel) != FMT_REAL);
    end else if (slot && pair_q) begin
      pair_q   <= 1'b0;
    end
  end
endmodule

// File: rtl/tof_port_map.sv
module tof_port_map
  import tof_pkg::*;
#(
  parameter int DW = 18,
  parameter int NP = 4
) (
  input  logic              start,
  input  logic              cont,
  input  fmt_e              mode_now,
  input  logic [NP*DW-1:0]  in_i,
  input  logic [NP/2*DW-1:0] split_q,
  input  logic [NP*DW-1:0]  hold_q,
  input  logic [NP*DW-1:0]  raw_q,
  output logic [NP*DW-1:0]  nxt_raw
);
  for (genvar p = 0; p < NP; p++) begin : g_port
    localparam int CH = p / 2;
    localparam bit IS_Q = (p % 2) == 1;
    logic [DW-1:0] w;
    always_comb begin
      w = raw_q[p*DW +: DW];
      if (start) begin
        if (mode_now == FMT_SPLIT)
          w = IS_Q ? split_q[CH*DW +: DW] : in_i[CH*DW +: DW];
        else
          w = in_i[p*DW +: DW];
      end else if (cont) begin
        w = hold_q[p*DW +: DW];
      end
    end
    assign nxt_raw[p*DW +: DW] = w;
  end
endmodule

// File: rtl/tx_out_formatter.sv
module tx_out_formatter
  import tof_pkg::*;
#(
  parameter int DW = 18,
  parameter int NP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             half_rate,
  input  logic [1:0]       fmt_sel,
  input  logic             in_valid,
  input  logic [NP*DW-1:0] in_i,
  input  logic [NP*DW-1:0] in_q,
  input  logic [NP-1:0]    port_en,
  input  logic [NP-1:0]    port_hiz,
  output logic [NP*DW-1:0] tx_data,
  output logic [NP-1:0]    tx_drive,
  output logic             tx_iflag,
  output logic             tx_stb
);
  localparam int W    = NP * DW;
  localparam int HALF = NP / 2;

  logic slot, start, cont;
  fmt_e mode_now;
  logic [W-1:0] hold_q, raw_q, nxt_raw;

  tof_rate_gen u_rate (
    .clk(clk), .rst(rst), .half_rate(half_rate), .slot(slot)
  );

  tof_seq u_seq (
    .clk(clk), .rst(rst), .slot(slot), .in_valid(in_valid),
    .fmt_sel(fmt_sel), .start(start), .cont(cont), .mode_now(mode_now)
  );

  tof_port_map #(.DW(DW), .NP(NP)) u_map (
    .start(start), .cont(cont), .mode_now(mode_now),
    .in_i(in_i), .split_q(in_q[HALF*DW-1:0]),
    .hold_q(hold_q), .raw_q(raw_q), .nxt_raw(nxt_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q   <= '0;
      raw_q    <= '0;
      tx_data  <= '0;
      tx_drive <= '0;
      tx_iflag <= 1'b0;
      tx_stb   <= 1'b0;
    end else begin
      tx_stb <= 1'b0;
      if (start) hold_q <= in_q;
      if (slot) begin
        raw_q    <= nxt_raw;
        tx_stb   <= start | cont;
        tx_iflag <= start && (mode_now == FMT_ILV);
        tx_drive <= port_en | ~port_hiz;
        for (int p = 0; p < NP; p++)
          tx_data[p*DW +: DW] <= port_en[p] ? nxt_raw[p*DW +: DW] : '0;
      end
    end
  end
endmodule

// File: rtl/tof_checker.sv
module tof_checker #(
  parameter int DW = 18,
  parameter int NP = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             half_rate,
  input logic [NP-1:0]    port_en,
  input logic [NP-1:0]    port_hiz,
  input logic [NP*DW-1:0] tx_data,
  input logic [NP-1:0]    tx_drive,
  input logic             tx_iflag,
  input logic             tx_stb
);
  AST_RESET_CLEAR: assert property (@(posedge clk) ($past(rst) && !rst) |-> (tx_data == '0 && tx_drive == '0 && !tx_iflag && !tx_stb)); // R1
  AST_HALF_GAP: assert property (@(posedge clk) disable iff (rst) (half_rate && tx_stb) |=> !tx_stb); // R2
  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst) (half_rate && tx_stb) |=> ($stable(tx_data) && $stable(tx_iflag))); // R2
  AST_IFLAG_STROBED: assert property (@(posedge clk) disable iff (rst) $rose(tx_iflag) |-> tx_stb); // R4
  AST_ILV_Q_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (!half_rate && tx_iflag) |=> !tx_iflag); // R4
  AST_DRIVE_MASK: assert property (@(posedge clk) disable iff (rst) tx_stb |-> (tx_drive == ($past(port_en) | ~$past(port_hiz)))); // R9

  for (genvar p = 0; p < NP; p++) begin : g_off
    AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst) (tx_stb && !$past(port_en[p])) |-> (tx_data[p*DW +: DW] == '0)); // R8
  end
endmodule

bind tx_out_formatter tof_checker #(.DW(DW), .NP(NP)) u_chk (
  .clk(clk), .rst(rst), .half_rate(half_rate), .port_en(port_en),
  .port_hiz(port_hiz), .tx_data(tx_data), .tx_drive(tx_drive),
  .tx_iflag(tx_iflag), .tx_stb(tx_stb)
);

// File: tb/tb_tx_out_formatter.sv
module tb_tx_out_formatter;
  localparam int DW = 18;
  localparam int NP = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, half_rate, in_valid;
  logic [1:0] fmt_sel;
  logic [NP-1:0] port_en, port_hiz;
  logic [NP*DW-1:0] in_i, in_q, tx_data;
  logic [NP-1:0] tx_drive;
  logic tx_iflag, tx_stb;
  logic [DW-1:0] di [NP];
  logic [DW-1:0] dq [NP];
  logic [DW-1:0] ow [NP];

  for (genvar p = 0; p < NP; p++) begin : g_pk
    assign in_i[p*DW +: DW] = di[p];
    assign in_q[p*DW +: DW] = dq[p];
    assign ow[p] = tx_data[p*DW +: DW];
  end

  tx_out_formatter #(.DW(DW), .NP(NP)) dut (
    .clk(clk), .rst(rst), .half_rate(half_rate), .fmt_sel(fmt_sel),
    .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .port_en(port_en),
    .port_hiz(port_hiz), .tx_data(tx_data), .tx_drive(tx_drive),
    .tx_iflag(tx_iflag), .tx_stb(tx_stb)
  );

  int nchk = 0, nerr = 0;
  bit done = 0;

  // bench model state
  logic m_tick, m_pair, m_flag, m_stb;
  logic [1:0] m_mode;
  logic [NP-1:0] m_drv;
  logic [DW-1:0] m_hq [NP];
  logic [DW-1:0] m_raw [NP];
  logic [DW-1:0] m_out [NP];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rw();
    return DW'($urandom);
  endfunction

  task automatic model_step();
    logic slot, tick_n;
    logic [1:0] md;
    slot   = !half_rate || m_tick;
    tick_n = half_rate ? !m_tick : 1'b0;
    if (rst) begin
      m_tick = 0; m_pair = 0; m_flag = 0; m_stb = 0; m_mode = 0; m_drv = '0;
      for (int p = 0; p < NP; p++) begin m_hq[p] = '0; m_raw[p] = '0; m_out[p] = '0; end
    end else begin
      if (slot) begin
        m_stb = 0; m_flag = 0;
        if (!m_pair && in_valid) begin
          md = (fmt_sel == 2'd3) ? 2'd0 : fmt_sel;
          m_mode = md;
          for (int p = 0; p < NP; p++) begin
            if (md == 2'd2) m_raw[p] = (p % 2 == 1) ? dq[p/2] : di[p/2];
            else            m_raw[p] = di[p];
            m_hq[p] = dq[p];
          end
          m_stb = 1; m_flag = (md == 2'd1); m_pair = (md != 2'd0);
        end else if (m_pair) begin
          if (m_mode == 2'd1) begin
            for (int p = 0; p < NP; p++) m_raw[p] = m_hq[p];
            m_stb = 1;
          end
          m_pair = 0;
        end
        for (int p = 0; p < NP; p++) m_out[p] = port_en[p] ? m_raw[p] : '0;
        m_drv = port_en | ~port_hiz;
      end else begin
        m_stb = 0;
      end
      m_tick = tick_n;
    end
  endtask

  task automatic compare();
    string tg;
    tg = (m_mode == 2'd2) ? "R5 split word" : (m_mode == 2'd1) ? "R4 interleaved word" : "R3 real word";
    for (int p = 0; p < NP; p++) chk(tg, 32'(ow[p]), 32'(m_out[p]));
    chk("R4 iflag", 32'(tx_iflag), 32'(m_flag));
    chk("R10 strobe", 32'(tx_stb), 32'(m_stb));
    chk("R9 drive", 32'(tx_drive), 32'(m_drv));
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic new_data();
    for (int p = 0; p < NP; p++) begin di[p] = rw(); dq[p] = rw(); end
  endtask

  logic [DW-1:0] si [NP];
  logic [DW-1:0] sq [NP];

  task automatic save();
    for (int p = 0; p < NP; p++) begin si[p] = di[p]; sq[p] = dq[p]; end
  endtask

  initial begin
    void'($urandom(32'd4711));
    rst = 1; half_rate = 0; in_valid = 0; fmt_sel = 0;
    port_en = '1; port_hiz = '0;
    for (int p = 0; p < NP; p++) begin di[p] = '0; dq[p] = '0; end
    step(); step();
    rst = 0;
    chk("R1 data after reset", 32'(tx_data[31:0]), 32'd0);
    chk("R1 strobe after reset", 32'(tx_stb), 32'd0);
    chk("R1 flag after reset", 32'(tx_iflag), 32'd0);
    chk("R1 drive after reset", 32'(tx_drive), 32'd0);

    // R3: real mode, code 0 then code 3
    new_data(); save(); in_valid = 1; fmt_sel = 2'd0; step();
    for (int p = 0; p < NP; p++) chk("R3 real port=I", 32'(ow[p]), 32'(si[p]));
    chk("R3 real flag low", 32'(tx_iflag), 32'd0);
    chk("R10 strobe on load", 32'(tx_stb), 32'd1);
    new_data(); save(); fmt_sel = 2'd3; step();
    for (int p = 0; p < NP; p++) chk("R3 code3 real", 32'(ow[p]), 32'(si[p]));

    // R7: no valid at boundary
    in_valid = 0; new_data(); step();
    for (int p = 0; p < NP; p++) chk("R7 hold", 32'(ow[p]), 32'(si[p]));
    chk("R7 no strobe", 32'(tx_stb), 32'd0);

    // R4: interleaved
    new_data(); save(); in_valid = 1; fmt_sel = 2'd1; step();
    for (int p = 0; p < NP; p++) chk("R4 I first", 32'(ow[p]), 32'(si[p]));
    chk("R4 flag with I", 32'(tx_iflag), 32'd1);
    new_data(); step();
    for (int p = 0; p < NP; p++) chk("R4 Q second", 32'(ow[p]), 32'(sq[p]));
    chk("R4 flag with Q", 32'(tx_iflag), 32'd0);
    chk("R10 strobe with Q", 32'(tx_stb), 32'd1);

    // R5: split
    new_data(); save(); fmt_sel = 2'd2; step();
    chk("R5 port0=I0", 32'(ow[0]), 32'(si[0]));
    chk("R5 port1=Q0", 32'(ow[1]), 32'(sq[0]));
    chk("R5 port2=I1", 32'(ow[2]), 32'(si[1]));
    chk("R5 port3=Q1", 32'(ow[3]), 32'(sq[1]));
    new_data(); step();
    chk("R5 idle slot no strobe", 32'(tx_stb), 32'd0);
    chk("R5 idle slot hold", 32'(ow[3]), 32'(sq[1]));
    new_data(); save(); step();
    chk("R5 next load", 32'(ow[1]), 32'(sq[0]));
    in_valid = 0; step();

    // R6: format change in the middle of a pair
    new_data(); save(); in_valid = 1; fmt_sel = 2'd1; step();
    fmt_sel = 2'd2; new_data(); step();
    for (int p = 0; p < NP; p++) chk("R6 pair completes interleaved", 32'(ow[p]), 32'(sq[p]));
    new_data(); save(); step();
    chk("R6 new code at boundary", 32'(ow[1]), 32'(sq[0]));
    in_valid = 0; step();

    // R8/R9: masks
    port_en = 4'b0101; port_hiz = 4'b0010;
    new_data(); save(); in_valid = 1; fmt_sel = 2'd0; step();
    chk("R8 port0 on", 32'(ow[0]), 32'(si[0]));
    chk("R8 port1 zero", 32'(ow[1]), 32'd0);
    chk("R8 port3 zero", 32'(ow[3]), 32'd0);
    chk("R9 drive mask", 32'(tx_drive), 32'b1101);
    port_en = '1; port_hiz = '0;

    // R2: half rate
    half_rate = 1; new_data(); save(); step();
    chk("R2 first half-rate edge no slot", 32'(tx_stb), 32'd0);
    step();
    chk("R2 second edge is slot", 32'(tx_stb), 32'd1);
    chk("R2 slot data", 32'(ow[2]), 32'(si[2]));
    new_data(); step();
    chk("R2 off-slot no strobe", 32'(tx_stb), 32'd0);
    chk("R2 off-slot hold", 32'(ow[2]), 32'(si[2]));

    // random segments
    for (int s = 0; s < 8; s++) begin
      half_rate = s[0];
      for (int n = 0; n < 1500; n++) begin
        in_valid = ($urandom_range(9) < 7);
        new_data();
        if ($urandom_range(9) < 3) fmt_sel = 2'($urandom_range(3));
        if ($urandom_range(19) == 0) begin
          port_en = 4'($urandom); port_hiz = 4'($urandom);
        end
        step();
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule